// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes that has two chip selects of opposite polarity (one active low, one active high), active-low write and output enables, and a shared 8-bit data bus. The host raises a request with a read/write flag, a 17-bit address and write data. The controller then walks the memory through a correctly spaced read cycle or a write cycle controlled by the write enable, and answers with a single-cycle acknowledge. A read also returns the byte it fetched.

Every phase length is a whole number of clock cycles. It is derived from a nanosecond timing figure and the clock period, rounded up, with a minimum of one cycle. Setup, write pulse, recovery, access and bus turnaround each have their own figure, so the block does not rely on a single wait count. The data bus is split into a pad-side output, an output enable and an input, so that the tri-state buffer lives in the pad ring. While no access is in progress the memory is held deselected, in standby.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and until the first request: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, host_ack=0, and host_rdata=0.
- R2: Outside an access (idle, the acknowledge cycle, turnaround) the memory is deselected: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0.
- R3: A request with host_write=0, seen at a rising edge while idle, starts a read. From the next cycle, for N_RD = max(ceil(tAA), ceil(tRC), ceil(tOE)) cycles: mem_addr is the request address, mem_cs1_n=0, mem_cs2=1, mem_oe_n=0, mem_we_n=1.
- R4: host_ack is high for exactly one cycle, the cycle after the last access or recovery cycle. After a read, host_rdata holds the byte present on mem_dq_i at the end of the last access cycle, and it keeps that value through later writes until the next read ends.
- R5: A write has three phases with mem_oe_n=1 throughout. Setup lasts N_AS = ceil(tAS) cycles, selected with mem_we_n=1. The pulse lasts N_WP = max(ceil(tWP), ceil(tDW), ceil(tAW) - N_AS) cycles with mem_we_n=0. Recovery lasts N_REC = max(ceil(tWR), ceil(tDH), ceil(tWC) - N_AS - N_WP) cycles with mem_we_n=1. The address and selects do not change across the three phases. ceil(t) means t divided by the clock period, rounded up, with a floor of 1.
- R6: mem_dq_oe=1 only during the write pulse and recovery, with mem_dq_o equal to the request's write data. The bus is never driven while mem_oe_n=0.
- R7: If the previous access was a read, an accepted write first spends N_TA = ceil(tOHZ) cycles deselected with mem_dq_oe=0 before setup starts.
- R8: A write after reset or after another write starts setup in the cycle after acceptance. Its acknowledge follows the last recovery cycle.
- R9: While not idle, changes on host_req, host_write, host_addr and host_wdata do not alter the memory-side outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last read byte |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data toward the pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_i | input | 8 | Data from the pad |

## Verification
All memory-side outputs are registered. Counting the accepting edge as edge 0, a read shows its first access cycle after edge 0 and its acknowledge with data after edge N_RD. A write acknowledges after edge N_AS+N_WP+N_REC, or after N_TA further edges when it follows a read. The bench drives requests just after a falling edge and samples at every falling edge of the transaction, comparing the pin pattern with the phase it expects in that cycle. It also holds the request through the acknowledge cycle and drops it there, so every transaction ends with an idle cycle that checks standby.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TURN = 3'd1,
    PH_RD   = 3'd2,
    PH_WSU  = 3'd3,
    PH_WPL  = 3'd4,
    PH_WRC  = 3'd5,
    PH_ACK  = 3'd6
  } phase_e;

  // ceil(ns / clk), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // cycles still owed to a total once some are already spent
  function automatic int unsigned rem_cyc(input int unsigned total, input int unsigned used);
    return (total > used) ? total - used : 0;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
`timescale 1ns/1ps
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)                 cnt_d = load_val;
    else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // last cycle of the running phase
  assign expire = (cnt_q <= CW'(1));

  // R5: every phase the sequencer starts lasts at least one cycle
  p_load_min_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq import asram_pkg::*; #(
  parameter int unsigned N_RD  = 4,
  parameter int unsigned N_AS  = 1,
  parameter int unsigned N_WP  = 2,
  parameter int unsigned N_REC = 1,
  parameter int unsigned N_TA  = 2,
  parameter int          CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          write,
  input  logic          expire,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          accept,
  output logic          load,
  output logic [CW-1:0] load_val
);
  logic rd_flag_q, rd_flag_d;

  always_comb begin
    phase_d   = phase_q;
    load      = 1'b0;
    load_val  = '0;
    accept    = 1'b0;
    rd_flag_d = rd_flag_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          accept = 1'b1;
          load   = 1'b1;
          if (write) begin
            rd_flag_d = 1'b0;
            if (rd_flag_q) begin
              phase_d  = PH_TURN;
              load_val = CW'(N_TA);
            end else begin
              phase_d  = PH_WSU;
              load_val = CW'(N_AS);
            end
          end else begin
            rd_flag_d = 1'b1;
            phase_d   = PH_RD;
            load_val  = CW'(N_RD);
          end
        end
      end
      PH_TURN: if (expire) begin
        phase_d = PH_WSU; load = 1'b1; load_val = CW'(N_AS);
      end
      PH_WSU: if (expire) begin
        phase_d = PH_WPL; load = 1'b1; load_val = CW'(N_WP);
      end
      PH_WPL: if (expire) begin
        phase_d = PH_WRC; load = 1'b1; load_val = CW'(N_REC);
      end
      PH_WRC:  if (expire) phase_d = PH_ACK;
      PH_RD:   if (expire) phase_d = PH_ACK;
      PH_ACK:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      rd_flag_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      rd_flag_q <= rd_flag_d;
    end
  end
endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins import asram_pkg::*; #(
  parameter int          AW   = 17,
  parameter int          DW   = 8,
  parameter int          CW   = 3,
  parameter int unsigned N_WP = 2,
  parameter int unsigned N_TA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_q,
  input  phase_e        phase_d,
  input  logic          expire,
  input  logic          accept,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe
);
  logic sel_d, we_n_d, oe_n_d, dq_oe_d, ack_d, capture;

  // pin levels decoded from the phase being entered, then registered
  always_comb begin
    sel_d   = phase_d inside {PH_RD, PH_WSU, PH_WPL, PH_WRC};
    we_n_d  = (phase_d != PH_WPL);
    oe_n_d  = (phase_d != PH_RD);
    dq_oe_d = phase_d inside {PH_WPL, PH_WRC};
    ack_d   = (phase_d == PH_ACK);
    capture = (phase_q == PH_RD) && expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      host_ack  <= 1'b0;
    end else begin
      mem_cs1_n <= !sel_d;
      mem_cs2   <= sel_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      host_ack  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      mem_dq_o <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (capture) host_rdata <= mem_dq_i;
  end

  // ---------------- checks on the pin timing ----------------
  logic [CW-1:0] wlow_q, oeh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_q <= '0;
      oeh_q  <= CW'(N_TA);
    end else begin
      if (!mem_we_n) wlow_q <= (wlow_q == '1) ? wlow_q : wlow_q + CW'(1);
      else           wlow_q <= '0;
      if (!mem_oe_n)                 oeh_q <= '0;
      else if (oeh_q < CW'(N_TA))    oeh_q <= oeh_q + CW'(1);
    end
  end

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_we_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $stable(mem_addr));

  p_wp_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_q == CW'(N_WP)));

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oeh_q == CW'(N_TA)));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  p_standby_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (mem_cs1_n && !mem_cs2 && !mem_dq_oe));
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl import asram_pkg::*; #(
  parameter int          AW       = 17,
  parameter int          DW       = 8,
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_OE_NS  = 25,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_WP_NS  = 35,
  parameter int unsigned T_AW_NS  = 60,
  parameter int unsigned T_AS_NS  = 0,
  parameter int unsigned T_DW_NS  = 35,
  parameter int unsigned T_DH_NS  = 0,
  parameter int unsigned T_WR_NS  = 5,
  parameter int unsigned T_OHZ_NS = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned N_RD  = max3(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS),
                                       ns2cyc(T_OE_NS, CLK_NS));
  localparam int unsigned N_AS  = ns2cyc(T_AS_NS, CLK_NS);
  localparam int unsigned N_WP  = max3(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS),
                                       rem_cyc(ns2cyc(T_AW_NS, CLK_NS), N_AS));
  localparam int unsigned N_REC = max3(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS),
                                       rem_cyc(ns2cyc(T_WC_NS, CLK_NS), N_AS + N_WP));
  localparam int unsigned N_TA  = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned N_MAX = max3(max3(N_RD, N_AS, N_WP), N_REC, N_TA);
  localparam int          CW    = $clog2(N_MAX + 1);

  logic          rst_s_n;
  phase_e        phase_q, phase_d;
  logic          accept, load, expire;
  logic [CW-1:0] load_val;

  asram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  asram_seq #(
    .N_RD(N_RD), .N_AS(N_AS), .N_WP(N_WP), .N_REC(N_REC), .N_TA(N_TA), .CW(CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .req      (host_req),
    .write    (host_write),
    .expire   (expire),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .accept   (accept),
    .load     (load),
    .load_val (load_val)
  );

  asram_pins #(
    .AW(AW), .DW(DW), .CW(CW), .N_WP(N_WP), .N_TA(N_TA)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .expire     (expire),
    .accept     (accept),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_i   (mem_dq_i),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .mem_addr   (mem_addr),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe)
  );
endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
  localparam int unsigned CLKP = 20;
  // bench's own phase lengths from the requirements, default timing at 20 ns
  function automatic int unsigned cy(input int unsigned ns);
    int unsigned c;
    c = (ns + CLKP - 1) / CLKP;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
  function automatic int unsigned sub0(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction
  localparam int unsigned B_RD  = mx(mx(cy(70), cy(70)), cy(25));
  localparam int unsigned B_AS  = cy(0);
  localparam int unsigned B_WP  = mx(mx(cy(35), cy(35)), sub0(cy(60), B_AS));
  localparam int unsigned B_REC = mx(mx(cy(5), cy(0)), sub0(cy(70), B_AS + B_WP));
  localparam int unsigned B_TA  = cy(30);

  // {cs1_n, cs2, we_n, oe_n, ack}
  localparam logic [4:0] C_IDLE = 5'b10110;
  localparam logic [4:0] C_RD   = 5'b01100;
  localparam logic [4:0] C_WSU  = 5'b01110;
  localparam logic [4:0] C_WP   = 5'b01010;
  localparam logic [4:0] C_ACK  = 5'b10111;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_write, host_ack;
  logic [16:0] host_addr, mem_addr;
  logic [7:0]  host_wdata, host_rdata, mem_dq_o, mem_dq_i;
  logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0;
  int errors = 0;
  bit prev_read = 1'b0;
  logic [7:0] last_rdata = 8'h00;

  logic [7:0] model_mem [logic [16:0]];
  logic [7:0] ref_mem   [logic [16:0]];

  always #10 clk = ~clk;

  asram_ctrl #(
    .CLK_NS(CLKP), .T_RC_NS(70), .T_AA_NS(70), .T_OE_NS(25), .T_WC_NS(70),
    .T_WP_NS(35), .T_AW_NS(60), .T_AS_NS(0), .T_DW_NS(35), .T_DH_NS(0),
    .T_WR_NS(5), .T_OHZ_NS(30)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // contents of a never-written location
  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] model_rd(input logic [16:0] a);
    return model_mem.exists(a) ? model_mem[a] : dflt(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction

  // memory model: drives on a selected read, stores at the rising write enable
  wire rd_en = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
  always @* mem_dq_i = mem_dq_oe ? mem_dq_o : (rd_en ? model_rd(mem_addr) : 8'h00);
  always @(posedge mem_we_n)
    if (rst_n && !mem_cs1_n && mem_cs2 && mem_dq_oe) model_mem[mem_addr] = mem_dq_o;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_pins(input string tag, input logic [4:0] ctl, input bit chk_a,
                            input logic [16:0] a, input bit oe, input logic [7:0] d);
    logic [4:0] act;
    act = {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, host_ack};
    check(act == ctl, tag, "control pins", 32'(act), 32'(ctl));
    if (chk_a) check(mem_addr == a, tag, "address", 32'(mem_addr), 32'(a));
    check(mem_dq_oe == oe, tag, "bus drive", 32'(mem_dq_oe), 32'(oe));
    if (oe) check(mem_dq_o == d, tag, "write data", 32'(mem_dq_o), 32'(d));
    if (mem_dq_oe && rd_en) check(1'b0, "R6", "bus contention", 32'd1, 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_read(input logic [16:0] a, input bit disturb);
    logic [7:0] e;
    e = ref_rd(a);
    host_req = 1'b1; host_write = 1'b0; host_addr = a;
    for (int k = 1; k <= int'(B_RD); k++) begin
      @(negedge clk);
      check_pins((disturb && k > 1) ? "R9" : "R3", C_RD, 1'b1, a, 1'b0, 8'h00);
      if (disturb && k == 1) begin
        host_write = 1'b1; host_addr = a ^ 17'h155AA; host_wdata = 8'hC3;
      end
    end
    @(negedge clk);
    check_pins("R4", C_ACK, 1'b0, a, 1'b0, 8'h00);
    check(host_rdata == e, "R4", "read data", 32'(host_rdata), 32'(e));
    host_req = 1'b0;
    @(negedge clk);
    check_pins("R2", C_IDLE, 1'b0, a, 1'b0, 8'h00);
    last_rdata = e;
    prev_read = 1'b1;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    host_req = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    if (prev_read)
      for (int k = 0; k < int'(B_TA); k++) begin
        @(negedge clk);
        check_pins("R7", C_IDLE, 1'b0, a, 1'b0, 8'h00);
      end
    for (int k = 0; k < int'(B_AS); k++) begin
      @(negedge clk);
      check_pins(prev_read ? "R5" : "R8", C_WSU, 1'b1, a, 1'b0, 8'h00);
    end
    for (int k = 0; k < int'(B_WP); k++) begin
      @(negedge clk);
      check_pins("R5", C_WP, 1'b1, a, 1'b1, d);
    end
    for (int k = 0; k < int'(B_REC); k++) begin
      @(negedge clk);
      check_pins("R6", C_WSU, 1'b1, a, 1'b1, d);
    end
    @(negedge clk);
    check_pins("R8", C_ACK, 1'b0, a, 1'b0, 8'h00);
    check(host_rdata == last_rdata, "R4", "read data held", 32'(host_rdata), 32'(last_rdata));
    host_req = 1'b0;
    @(negedge clk);
    check_pins("R2", C_IDLE, 1'b0, a, 1'b0, 8'h00);
    ref_mem[a] = d;
    prev_read = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; host_req = 1'b0; host_write = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    check_pins("R1", C_IDLE, 1'b0, '0, 1'b0, 8'h00);
    check(host_rdata == 8'h00, "R1", "read data at reset", 32'(host_rdata), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pins("R1", C_IDLE, 1'b0, '0, 1'b0, 8'h00);

    // directed corners
    do_write(17'h00010, 8'hA5);          // R8: write straight after reset
    do_write(17'h1FFFF, 8'h3C);          // R8: write after write
    do_read(17'h00010, 1'b0);            // R3
    do_write(17'h00011, 8'h96);          // R7: write after read
    do_read(17'h1FFFF, 1'b1);            // R9: inputs change mid-access
    do_read(17'h00000, 1'b0);            // unwritten location
    do_write(17'h00000, 8'hFF);
    do_read(17'h00000, 1'b0);
    do_read(17'h00011, 1'b0);

    for (int n = 0; n < 300; n++) begin
      r = $urandom;
      for (int g = 0; g < int'(r[9:8]); g++) begin
        @(negedge clk);
        check_pins("R2", C_IDLE, 1'b0, '0, 1'b0, 8'h00);
      end
      if (r[10]) do_write({r[1:0], 11'd0, r[5:2]}, r[23:16]);
      else       do_read({r[1:0], 11'd0, r[5:2]}, r[11] & r[12]);
    end
    finish_run();
  end
endmodule